// File: doc/BRIEF.md
# Table-Driven Systolic Resampling Interpolator

This block is a linear chain of multiply-accumulate cells that computes one interpolated output pixel per clock from a K×K neighbourhood. The default is K = 4, which gives 16 cells. Two pixel streams, A and B, move down the chain at half the speed of the partial sums. Every cell owns a weight table. An output pixel enters the chain as a token that carries a fractional address. The upper FRAC_W bits of that address are the line fraction and the lower FRAC_W bits are the pixel fraction. The address moves one cell per cycle, alongside the growing partial sum. Each cell fetches its weight with that address, so the kernel can change on every output pixel. This is the core of an image warper: an outside stage supplies the sub-pixel positions and the weight values.

Each cell table has two banks, one live and one standby. A write port, separate from the data paths, fills the standby bank of one chosen cell per clock while results keep flowing. A swap strobe travels down the chain with the tokens. It flips each cell's live bank at the moment a particular token reaches that cell. As a result, every result is formed from a single weight set. FRAC_W = 5 gives the 32×32 sub-pixel grid with 1024-entry tables. The default is kept small so that elaboration stays light.

Top module: `resamp_array`

## Requirements
- R1: A token launched with tok_vld_i at clock edge n appears at y_vld_o, with its result on y_o and its address on y_addr_o, after clock edge n+K². y_vld_o is never high without a matching launch.
- R2: The result is y = Σc Wc[addr]·xs(n−c) over cells c = 0..K²−1. Pixels are unsigned and weights are signed two's complement. xs(m) is the stream-s pixel sampled at edge m. Stream s is B (1) when ((n+c) div K) mod 2 = 1 and A (0) otherwise, so each cell uses one stream for K cycles and then switches.
- R3: Edges are counted from the first edge after reset release. Pixel samples from before that edge count as zero, bank 0 is live in every cell, and the stream-select phase restarts at zero.
- R4: tok_addr_i = {line fraction, pixel fraction}. Each cell holds 2^(2·FRAC_W) weights per bank, and each token uses its own address in every cell.
- R5: A write with wr_en_i stores wr_data_i at wr_addr_i in the standby bank of cell wr_cell_i. It does not change any result until a swap makes that bank live. Writes never coincide with a swap passing the same cell.
- R6: The token launched in the cycle of swap_i, and every later token, uses the other bank in all cells. Every earlier token completes entirely on the previous bank.
- R7: Two swap strobes are at least K² cycles apart, so that at most one set change ripples down the chain at a time.
- R8: Accumulation is exact at ACC_W bits. With all pixels at 255 and all weights at −2048, the result is −8355840.
- R9: While rst_ni is low, y_vld_o and y_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xa_i | input | PIX_W | Pixel stream A sample |
| xb_i | input | PIX_W | Pixel stream B sample |
| tok_vld_i | input | 1 | Launch an output-pixel token this cycle |
| tok_addr_i | input | 2·FRAC_W | Fractional position {line, pixel} of the token |
| swap_i | input | 1 | Set-swap strobe, rippling with the token of this cycle |
| wr_en_i | input | 1 | Weight write enable |
| wr_cell_i | input | clog2(K²) | Target cell of the write |
| wr_addr_i | input | 2·FRAC_W | Table entry to write |
| wr_data_i | input | WT_W | Signed weight value |
| y_vld_o | output | 1 | Result valid |
| y_addr_o | output | 2·FRAC_W | Address of the token that produced the result |
| y_o | output | ACC_W | Signed accumulated result |

## Verification
Each result is due exactly K² = 16 edges after its token is launched. The bench computes that result when it drives the token and files it in an expected array indexed by the due edge. At the falling edge after every rising edge, it compares y_vld_o against that array, and it compares y_o and y_addr_o wherever a result is due. The bank a token should use is fixed by the bench's own swap count at launch time. Stream choice and pixel age are derived from the launch edge, counted from reset release. A mid-run reset therefore restarts that count and checks the zero pixel history.

// File: rtl/resamp_pkg.sv
package resamp_pkg;
  localparam int KERN_D   = 4;
  localparam int PIX_W_D  = 8;
  localparam int WT_W_D   = 12;
  localparam int ACC_W_D  = 24;
  localparam int FRAC_W_D = 2;

  typedef enum logic {STRM_A = 1'b0, STRM_B = 1'b1} strm_e;
endpackage

// File: rtl/resamp_wtab.sv
module resamp_wtab #(
  parameter int ADDR_W = 4,
  parameter int WT_W   = 12
) (
  input  logic              clk_i,
  input  logic              rd_bank_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WT_W-1:0]   rd_data_o,
  input  logic              wr_en_i,
  input  logic              wr_bank_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WT_W-1:0]   wr_data_i
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WT_W-1:0] mem [2][DEPTH];
  logic [WT_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_bank_i][wr_addr_i] <= wr_data_i;
  end

  // registered read: weight lines up with the sum one stage later
  always_ff @(posedge clk_i) begin
    rd_q <= mem[rd_bank_i][rd_addr_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/resamp_cell.sv
module resamp_cell
  import resamp_pkg::*;
#(
  parameter int KERN   = 4,
  parameter int PIX_W  = 8,
  parameter int WT_W   = 12,
  parameter int ACC_W  = 24,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  xa_i,
  input  logic [PIX_W-1:0]  xb_i,
  output logic [PIX_W-1:0]  xa_o,
  output logic [PIX_W-1:0]  xb_o,
  input  logic              tok_vld_i,
  input  logic [ADDR_W-1:0] tok_addr_i,
  input  logic              tok_swap_i,
  output logic              tok_vld_o,
  output logic [ADDR_W-1:0] tok_addr_o,
  output logic              tok_swap_o,
  input  logic [ACC_W-1:0]  sum_i,
  output logic [ACC_W-1:0]  sum_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WT_W-1:0]   wr_data_i
);
  localparam int PH_W   = $clog2(2 * KERN);
  localparam int PROD_W = PIX_W + WT_W + 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * KERN - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(KERN);

  logic [PIX_W-1:0] xa1_q, xa2_q, xb1_q, xb2_q;
  logic             act_q;
  logic             vld_q, swap_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PH_W-1:0]  ph_q;
  logic [WT_W-1:0]  w_q;
  logic [ACC_W-1:0] sum_q;
  strm_e            sel;
  logic [PIX_W-1:0] x_use;
  logic signed [PROD_W-1:0] prod;
  logic [ACC_W:0]   sum_wide;

  // two registers per stream: pixels move at half the speed of sums
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xa1_q <= '0; xa2_q <= '0; xb1_q <= '0; xb2_q <= '0;
    end else begin
      xa1_q <= xa_i; xa2_q <= xa1_q;
      xb1_q <= xb_i; xb2_q <= xb1_q;
    end
  end
  assign xa_o = xa2_q;
  assign xb_o = xb2_q;

  // token stage: address, valid and swap marker, live bank flip
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      swap_q <= 1'b0;
      addr_q <= '0;
      act_q  <= 1'b0;
    end else begin
      vld_q  <= tok_vld_i;
      swap_q <= tok_swap_i;
      addr_q <= tok_addr_i;
      act_q  <= act_q ^ tok_swap_i;
    end
  end
  assign tok_vld_o  = vld_q;
  assign tok_swap_o = swap_q;
  assign tok_addr_o = addr_q;

  resamp_wtab #(.ADDR_W(ADDR_W), .WT_W(WT_W)) u_wtab (
    .clk_i     (clk_i),
    .rd_bank_i (act_q ^ tok_swap_i),
    .rd_addr_i (tok_addr_i),
    .rd_data_o (w_q),
    .wr_en_i   (wr_en_i),
    .wr_bank_i (~act_q),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i)
  );

  // stream phase: K cycles on one stream, then K on the other
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_LAST;
    else         ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
  end
  assign sel   = (ph_q >= PH_HALF) ? STRM_B : STRM_A;
  assign x_use = (sel == STRM_B) ? xb1_q : xa1_q;

  assign prod     = $signed({1'b0, x_use}) * $signed(w_q);
  assign sum_wide = {sum_i[ACC_W-1], sum_i}
                  + {{(ACC_W + 1 - PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= sum_wide[ACC_W-1:0];
  end
  assign sum_o = sum_q;

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (sum_wide[ACC_W] == sum_wide[ACC_W-1]));

  assert_standby_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && tok_swap_i));
endmodule

// File: rtl/resamp_array.sv
module resamp_array
  import resamp_pkg::*;
#(
  parameter int KERN   = KERN_D,
  parameter int PIX_W  = PIX_W_D,
  parameter int WT_W   = WT_W_D,
  parameter int ACC_W  = ACC_W_D,
  parameter int FRAC_W = FRAC_W_D,
  localparam int NCELL  = KERN * KERN,
  localparam int ADDR_W = 2 * FRAC_W,
  localparam int CELL_W = $clog2(NCELL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  xa_i,
  input  logic [PIX_W-1:0]  xb_i,
  input  logic              tok_vld_i,
  input  logic [ADDR_W-1:0] tok_addr_i,
  input  logic              swap_i,
  input  logic              wr_en_i,
  input  logic [CELL_W-1:0] wr_cell_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WT_W-1:0]   wr_data_i,
  output logic              y_vld_o,
  output logic [ADDR_W-1:0] y_addr_o,
  output logic [ACC_W-1:0]  y_o
);
  localparam int SW_W = $clog2(NCELL + 1) + 1;
  localparam int TK_W = $clog2(NCELL + 2) + 1;

  logic [PIX_W-1:0]  xa_c   [NCELL+1];
  logic [PIX_W-1:0]  xb_c   [NCELL+1];
  logic              vld_c  [NCELL+1];
  logic              swp_c  [NCELL+1];
  logic [ADDR_W-1:0] addr_c [NCELL+1];
  logic [ACC_W-1:0]  sum_c  [NCELL+1];
  logic [PIX_W-1:0]  unused_xa, unused_xb;

  assign xa_c[0]   = xa_i;
  assign xb_c[0]   = xb_i;
  assign vld_c[0]  = tok_vld_i;
  assign swp_c[0]  = swap_i;
  assign addr_c[0] = tok_addr_i;
  assign sum_c[0]  = '0;
  assign unused_xa = xa_c[NCELL];
  assign unused_xb = xb_c[NCELL];

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    logic wr_hit;
    assign wr_hit = wr_en_i && (wr_cell_i == CELL_W'(c));

    resamp_cell #(
      .KERN(KERN), .PIX_W(PIX_W), .WT_W(WT_W), .ACC_W(ACC_W), .ADDR_W(ADDR_W)
    ) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .xa_i       (xa_c[c]),
      .xb_i       (xb_c[c]),
      .xa_o       (xa_c[c+1]),
      .xb_o       (xb_c[c+1]),
      .tok_vld_i  (vld_c[c]),
      .tok_addr_i (addr_c[c]),
      .tok_swap_i (swp_c[c]),
      .tok_vld_o  (vld_c[c+1]),
      .tok_addr_o (addr_c[c+1]),
      .tok_swap_o (swp_c[c+1]),
      .sum_i      (sum_c[c]),
      .sum_o      (sum_c[c+1]),
      .wr_en_i    (wr_hit),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i)
    );
  end

  // token side leads the sum by one stage; realign at the edge
  logic              y_vld_q;
  logic [ADDR_W-1:0] y_addr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_vld_q  <= 1'b0;
      y_addr_q <= '0;
    end else begin
      y_vld_q  <= vld_c[NCELL];
      y_addr_q <= addr_c[NCELL];
    end
  end
  assign y_vld_o  = y_vld_q;
  assign y_addr_o = y_addr_q;
  assign y_o      = sum_c[NCELL];

  // swaps in flight down the chain
  logic [SW_W-1:0] swap_live;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) swap_live <= '0;
    else begin
      case ({swap_i, swp_c[NCELL]})
        2'b10:   swap_live <= swap_live + SW_W'(1);
        2'b01:   swap_live <= swap_live - SW_W'(1);
        default: swap_live <= swap_live;
      endcase
    end
  end

  // tokens launched but not yet delivered
  logic [TK_W-1:0] tok_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tok_cnt <= '0;
    else begin
      case ({tok_vld_i, y_vld_o})
        2'b10:   tok_cnt <= tok_cnt + TK_W'(1);
        2'b01:   tok_cnt <= tok_cnt - TK_W'(1);
        default: tok_cnt <= tok_cnt;
      endcase
    end
  end

  assert_swap_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |-> (swap_live == '0 || swp_c[NCELL]));

  assert_latency_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_cnt <= TK_W'(NCELL + 1));

  assert_no_phantom_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_vld_o |-> (tok_cnt != '0));
endmodule

// File: tb/sim_resamp_array.sv
module sim_resamp_array;
  localparam int K  = 4;
  localparam int N  = K * K;
  localparam int HS = 4096;

  // {swap[21], vld[20], addr[19:16], xb[15:8], xa[7:0]}
  localparam logic [21:0] STIM [24] = '{
    22'h1010F0, 22'h112001, 22'h1FFFFF, 22'h033344, 22'h17807F, 22'h180000,
    22'h1A5AA5, 22'h12C33C, 22'h1001FE, 22'h1D9966, 22'h351234, 22'h151234,
    22'h1FEE11, 22'h1000FF, 22'h097788, 22'h164004, 22'h1BABCD, 22'h1C0FF0,
    22'h115555, 22'h13FE02, 22'h148118, 22'h1E3CC3, 22'h196699, 22'h172442
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  xa_i = '0, xb_i = '0;
  logic        tok_vld_i = 1'b0, swap_i = 1'b0, wr_en_i = 1'b0;
  logic [3:0]  tok_addr_i = '0, wr_cell_i = '0, wr_addr_i = '0;
  logic [11:0] wr_data_i = '0;
  logic        y_vld_o;
  logic [3:0]  y_addr_o;
  logic [23:0] y_o;

  resamp_array u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .xa_i(xa_i), .xb_i(xb_i),
    .tok_vld_i(tok_vld_i), .tok_addr_i(tok_addr_i), .swap_i(swap_i),
    .wr_en_i(wr_en_i), .wr_cell_i(wr_cell_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .y_vld_o(y_vld_o), .y_addr_o(y_addr_o), .y_o(y_o)
  );

  always #5 clk_i = ~clk_i;

  int    nchk = 0, nerr = 0, n = 0, cur_bank = 0;
  bit    done = 0;
  int    wm [2][N][N];
  int    ha [HS], hb [HS];
  bit    exp_v [HS];
  int    exp_y [HS], exp_a [HS];
  string exp_tag [HS];

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int wgen(input int which, input int c, input int a);
    case (which)
      0:       return ((c * 37 + a * 91) % 1500) - 750;
      1:       return ((c * 113 + a * 59 + 17) % 4000) - 2000;
      default: return -2048;
    endcase
  endfunction

  // one clock: drive at negedge, model, then check the edge just taken
  task automatic cyc(input logic [7:0] xa, input logic [7:0] xb, input logic v,
                     input logic [3:0] a, input logic sw, input logic we,
                     input int wc, input int wa, input int wd, input string tag);
    xa_i = xa; xb_i = xb; tok_vld_i = v; tok_addr_i = a; swap_i = sw;
    wr_en_i = we; wr_cell_i = 4'(wc); wr_addr_i = 4'(wa); wr_data_i = 12'(wd);
    ha[n] = int'(xa); hb[n] = int'(xb);
    if (sw) cur_bank ^= 1;
    if (we) wm[cur_bank ^ 1][wc][wa] = wd;
    if (v) begin
      int acc = 0;
      for (int c = 0; c < N; c++) begin
        int idx = n - c;
        int s = ((n + c) / K) % 2;
        int x = (idx < 0) ? 0 : (s == 1 ? hb[idx] : ha[idx]);
        acc += wm[cur_bank][c][a] * x;
      end
      exp_v[n + N] = 1'b1; exp_y[n + N] = acc; exp_a[n + N] = int'(a);
      exp_tag[n + N] = tag;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 valid timing", int'(y_vld_o), int'(exp_v[n]));
    if (exp_v[n]) begin
      chk({exp_tag[n], " result"}, int'($signed(y_o)), exp_y[n]);
      chk("R4 address tag", int'(y_addr_o), exp_a[n]);
    end
    n++;
  endtask

  task automatic idle(input int cnt, input logic [7:0] xv);
    for (int i = 0; i < cnt; i++) cyc(xv, xv ^ 8'h5A, 0, 0, 0, 0, 0, 0, 0, "R2");
  endtask

  task automatic clear_model();
    for (int i = 0; i < HS; i++) begin
      exp_v[i] = 1'b0; ha[i] = 0; hb[i] = 0;
    end
    n = 0; cur_bank = 0;
  endtask

  initial begin : watchdog
    #(2_000_000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin : main
    clear_model();
    repeat (3) @(negedge clk_i);
    chk("R9 reset valid", int'(y_vld_o), 0);
    chk("R9 reset data", int'(y_o), 0);
    rst_ni = 1'b1;

    // set A into standby bank 1, then make it live
    for (int c = 0; c < N; c++)
      for (int a = 0; a < N; a++)
        cyc(8'((c * 16 + a) * 7), 8'(a * 3), 0, 0, 0, 1, c, a, wgen(0, c, a), "R5");
    cyc(8'h10, 8'h20, 0, 0, 1, 0, 0, 0, 0, "R6");
    idle(20, 8'h33);

    // R5: rewrite standby (set B) while tokens stream on set A
    for (int c = 0; c < N; c++)
      for (int a = 0; a < N; a++)
        cyc(8'((n * 13 + 5) % 256), 8'((n * 29 + 100) % 256), 1, 4'(n % 16),
            0, 1, c, a, wgen(1, c, a), "R5");

    // table walk: R4 addresses, R6 swap at entry 10 (to set B)
    for (int i = 0; i < 24; i++) begin
      logic [21:0] e = STIM[i];
      cyc(e[7:0], e[15:8], e[20], e[19:16], e[21], 0, 0, 0, 0,
          (i >= 10) ? "R6" : "R4");
    end
    idle(20, 8'h77);

    // R8: extreme set into bank 1 with saturated pixels
    for (int c = 0; c < N; c++)
      for (int a = 0; a < N; a++)
        cyc(8'hFF, 8'hFF, 0, 0, 0, 1, c, a, wgen(2, c, a), "R8");
    for (int i = 0; i < N; i++)
      cyc(8'hFF, 8'hFF, 1, 4'(i), (i == 0), 0, 0, 0, 0, "R8");
    // R7: next swap exactly K*K cycles later, back to set B
    for (int i = 0; i < 20; i++)
      cyc(8'(i * 11 + 3), 8'(250 - i * 9), 1, 4'(15 - (i % 16)), (i == 0),
          0, 0, 0, 0, "R7");
    idle(20, 8'h00);

    // R3 and R9: mid-run reset; bank 0 (set B) live, zero pixel history
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R9 reset valid", int'(y_vld_o), 0);
    chk("R9 reset data", int'(y_o), 0);
    clear_model();
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++)
      cyc(8'((i + 1) * 10), 8'(200 - i * 7), 1, 4'(i * 2), 0, 0, 0, 0, 0, "R3");
    idle(20, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule